// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Write Controller

This block is a clocked model of the control logic in a byte-wide parallel nonvolatile memory. It samples three active-low strobes (chip enable, output enable and write enable), a separate input that marks the output-enable pin as raised to the high-voltage level, an address bus and a data bus. The bidirectional data pin is split into an input bus, an output bus and an output-enable flag. All of these pass through two-flop synchronisers, and every timing limit is counted in system clock cycles. From the strobes the block decodes read, write, write-inhibit, standby and chip-clear.

Accepted bytes collect in a page buffer of 64 slots, each with its own valid bit. Each accepted byte reopens a byte-load window. When the window runs out with no new write, a timed program cycle starts. While it runs, the block pulls its open-drain ready/busy line low and a read returns the data-polling value. When the cycle ends, only the loaded bytes are copied into the storage array. Chip clear, and reset, run a sweep that sets every byte to all ones.

Top module: `eep_page_ctrl`

## Requirements
- R1: Reset holds and then releases into an erase sweep. The busy pull-down is asserted throughout, for DEPTH cycles (DEPTH = 2^ADDR_W), and afterwards every byte reads 0xFF.
- R2: With chip enable low, output enable low, write enable high and the high-voltage input low, data_oe is 1 and data_out carries the byte stored at the address. With chip enable high (standby), data_oe is 0.
- R3: A byte is taken only while chip enable and write enable are low and output enable is high. With output enable low the strobe is ignored: no program cycle starts and the byte is unchanged.
- R4: A write-active interval that lasts fewer than FILT_CYC synchronised cycles is discarded. An interval of exactly FILT_CYC cycles is taken.
- R5: The address is captured when the write-active interval begins. The data is captured from its last cycle.
- R6: Address bits [5:0] select the slot within a page. The upper address bits of the page come from the first byte of a load, and the upper bits of later bytes are ignored. A second write to the same slot replaces the first. A load can fill all 64 slots.
- R7: Each accepted byte, and any write-active interval, restarts a WIN_CYC-cycle window. The program cycle begins only when the window expires.
- R8: The program cycle holds the busy pull-down for exactly PROG_CYC cycles. At its end the loaded bytes are written and the unloaded bytes of the page keep their old value.
- R9: Writes that arrive while busy is asserted are ignored.
- R10: A read while busy returns the inverse of bit 7 of the last loaded byte on data_out[7], with data_out[6:0] = 0. During a chip-clear sweep, bit 7 reads 0.
- R11: Chip enable low, write enable low and the high-voltage input high, held for FILT_CYC cycles, start an erase sweep of DEPTH busy cycles. After it every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_hv | input | 1 | Output-enable pin at the high-voltage level |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Data bus, inbound half |
| data_out | output | 8 | Data bus, outbound half |
| data_oe | output | 1 | Drive enable for the data bus |
| rb_pulldown | output | 1 | 1 = open-drain ready/busy line pulled low (busy) |

## Verification
The bench builds the block with ADDR_W=8, FILT_CYC=3, WIN_CYC=24 and PROG_CYC=40. The array then holds four pages, so a full 64-byte page and a complete erase sweep of 256 cycles both fit in a short run. Strobe widths of 1, 2 and 3 cycles fall on either side of the filter threshold. Busy spans are counted cycle by cycle against exact expected lengths. A write placed inside the window shows that the window restarts, and polling reads and stray writes fit inside the 40-cycle program cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned PG_OFS_W = 6;
    localparam int unsigned PG_BYTES = 1 << PG_OFS_W;

    typedef enum logic [1:0] {
        ST_ERASE,
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } eep_state_e;

    // Synchronised strobe set; active-low pins keep their polarity.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic hv;
    } strobe_t;

    // One byte on its way into the page buffer.
    typedef struct packed {
        logic [PG_OFS_W-1:0] ofs;
        logic [BYTE_W-1:0]   dat;
    } load_t;

    function automatic logic is_read(strobe_t s);
        return !s.ce_n && !s.oe_n && s.we_n && !s.hv;
    endfunction

    function automatic logic is_write(strobe_t s);
        return !s.ce_n && !s.we_n && s.oe_n && !s.hv;
    endfunction

    function automatic logic is_clear(strobe_t s);
        return !s.ce_n && !s.we_n && s.hv;
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/eep_pulse_qual.sv
// Minimum-width qualifier. ON_RELEASE=1 fires once when a long enough
// interval ends; ON_RELEASE=0 fires once when the interval reaches MIN_CYC.
module eep_pulse_qual #(
    parameter int unsigned MIN_CYC    = 2,
    parameter bit          ON_RELEASE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYC);

    logic [CNT_W-1:0] width_cnt;

    always_ff @(posedge clk) begin
        if (rst || !level)
            width_cnt <= '0;
        else if (width_cnt != CNT_MAX)
            width_cnt <= width_cnt + 1'b1;
    end

    generate
        if (ON_RELEASE) begin : g_release
            logic level_q;
            always_ff @(posedge clk) begin
                if (rst) level_q <= 1'b0;
                else     level_q <= level;
            end
            assign done = level_q && !level && (width_cnt == CNT_MAX);
        end else begin : g_hold
            assign done = level && (width_cnt == CNT_MAX - 1'b1);
        end
    endgenerate

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  load_t                            ld,
    input  logic                             clr,
    output logic [PG_BYTES-1:0][BYTE_W-1:0]  bytes,
    output logic [PG_BYTES-1:0]              mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes <= '1;
            mask  <= '0;
        end else if (clr) begin
            mask  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < PG_BYTES; i++) begin
                if (ld.ofs == PG_OFS_W'(i)) begin
                    bytes[i] <= ld.dat;
                    mask[i]  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned FILT_CYC = 2,
    parameter int unsigned WIN_CYC  = 10000,
    parameter int unsigned PROG_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              rb_pulldown
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned PAGE_W = ADDR_W - PG_OFS_W;
    localparam int unsigned WIN_W  = $clog2(WIN_CYC + 1);
    localparam int unsigned PRG_W  = $clog2(PROG_CYC + 1);
    localparam int unsigned BUS_W  = ADDR_W + BYTE_W;
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
    localparam logic [PRG_W-1:0]  PRG_LAST  = PRG_W'(PROG_CYC - 1);
    localparam logic [ADDR_W-1:0] SWEEP_END = ADDR_W'(DEPTH - 1);

    // ---------------- input synchronisation ----------------
    strobe_t            strb_raw, strb_s;
    logic [BUS_W-1:0]   bus_s;
    logic [ADDR_W-1:0]  addr_s;
    logic [BYTE_W-1:0]  dat_s;

    assign strb_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, hv: oe_hv};

    eep_sync #(.W(4), .RST_VAL(4'b1110)) u_sync_strb (
        .clk (clk), .rst (rst), .d (strb_raw), .q (strb_s)
    );

    eep_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
        .clk (clk), .rst (rst), .d ({addr, data_in}), .q (bus_s)
    );

    assign addr_s = bus_s[BUS_W-1:BYTE_W];
    assign dat_s  = bus_s[BYTE_W-1:0];

    // ---------------- mode decode and strobe capture ----------------
    logic wr_level, clr_level, rd_level;
    logic wr_q, wr_accept, clr_go;
    logic [ADDR_W-1:0] addr_lat;
    logic [BYTE_W-1:0] dat_lat;

    assign wr_level  = is_write(strb_s);
    assign clr_level = is_clear(strb_s);
    assign rd_level  = is_read(strb_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            addr_lat <= '0;
            dat_lat  <= '0;
        end else begin
            wr_q <= wr_level;
            if (wr_level && !wr_q) addr_lat <= addr_s;   // last strobe to fall
            if (wr_level)          dat_lat  <= dat_s;    // held until first to rise
        end
    end

    eep_pulse_qual #(.MIN_CYC(FILT_CYC), .ON_RELEASE(1'b1)) u_wr_qual (
        .clk (clk), .rst (rst), .level (wr_level), .done (wr_accept)
    );

    eep_pulse_qual #(.MIN_CYC(FILT_CYC), .ON_RELEASE(1'b0)) u_clr_qual (
        .clk (clk), .rst (rst), .level (clr_level), .done (clr_go)
    );

    // ---------------- sequencing ----------------
    eep_state_e         state;
    logic [WIN_W-1:0]   win_cnt;
    logic [PRG_W-1:0]   prg_cnt;
    logic [ADDR_W-1:0]  sweep;
    logic [PAGE_W-1:0]  base;
    logic               poll7;
    logic               buf_wr, commit;
    load_t              ld;
    logic [PG_BYTES-1:0][BYTE_W-1:0] pg_bytes;
    logic [PG_BYTES-1:0]             pg_mask;

    assign buf_wr = wr_accept && (state == ST_IDLE || state == ST_LOAD);
    assign commit = (state == ST_PROG) && (prg_cnt == PRG_LAST);
    assign ld     = '{ofs: addr_lat[PG_OFS_W-1:0], dat: dat_lat};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ERASE;
            win_cnt <= '0;
            prg_cnt <= '0;
            sweep   <= '0;
            base    <= '0;
            poll7   <= 1'b0;
        end else begin
            if (buf_wr) poll7 <= ~dat_lat[BYTE_W-1];
            unique case (state)
                ST_ERASE: begin
                    sweep <= sweep + 1'b1;
                    if (sweep == SWEEP_END) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (clr_go) begin
                        state <= ST_ERASE;
                        sweep <= '0;
                        poll7 <= 1'b0;
                    end else if (wr_accept) begin
                        state   <= ST_LOAD;
                        base    <= addr_lat[ADDR_W-1:PG_OFS_W];
                        win_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    if (wr_accept || wr_level) begin
                        win_cnt <= '0;
                    end else if (win_cnt == WIN_LAST) begin
                        state   <= ST_PROG;
                        prg_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit) state <= ST_IDLE;
                    else        prg_cnt <= prg_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    eep_page_buf u_page (
        .clk   (clk),
        .rst   (rst),
        .wr_en (buf_wr),
        .ld    (ld),
        .clr   (commit),
        .bytes (pg_bytes),
        .mask  (pg_mask)
    );

    // ---------------- storage array ----------------
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (state == ST_ERASE) begin
            mem[sweep] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PG_BYTES; i++) begin
                if (pg_mask[i]) mem[{base, PG_OFS_W'(i)}] <= pg_bytes[i];
            end
        end
    end

    // ---------------- read path and status ----------------
    assign rb_pulldown = (state == ST_ERASE) || (state == ST_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end else begin
            data_oe  <= rd_level;
            data_out <= rb_pulldown ? {poll7, {(BYTE_W-1){1'b0}}} : mem[addr_s];
        end
    end

endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk
    import eep_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ce_n,
    input logic                data_oe,
    input logic [BYTE_W-1:0]   data_out,
    input logic                rb_pulldown,
    input logic [PG_BYTES-1:0] vmask
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    // R2: three cycles of standby leave the data bus undriven
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(ce_n, 1) && $past(ce_n, 2) && $past(ce_n, 3)) |-> !data_oe);

    // R10: the polling value does not move while busy persists
    a_r10_poll_steady: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && rb_pulldown && $past(rb_pulldown, 1) && $past(rb_pulldown, 2))
            |-> $stable(data_out));

    // R8: busy ends with an empty page buffer
    a_r8_mask_empty_after: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $fell(rb_pulldown)) |-> (vmask == '0));

    // R9: nothing enters the page buffer while busy
    a_r9_mask_frozen: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && rb_pulldown && $past(rb_pulldown)) |-> $stable(vmask));

endmodule

bind eep_page_ctrl eep_page_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .rb_pulldown (rb_pulldown),
    .vmask       (pg_mask)
);

// File: tb/eep_page_ctrl_test.sv
module eep_page_ctrl_test;

    localparam int AW    = 8;
    localparam int FILT  = 3;
    localparam int WIN   = 24;
    localparam int PROG  = 40;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic       flush;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{8'h00, 8'hA5, 1'b0},
        '{8'h3F, 8'h3C, 1'b0},
        '{8'h17, 8'h80, 1'b0},
        '{8'h01, 8'h7E, 1'b1},
        '{8'h80, 8'hC3, 1'b0},
        '{8'hBF, 8'h00, 1'b1},
        '{8'h42, 8'h81, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          data_oe, rb_pulldown;

    int nchk = 0;
    int nerr = 0;
    int run = 0;
    int last_run = 0;

    always #4 clk = ~clk;

    eep_page_ctrl #(
        .ADDR_W(AW), .FILT_CYC(FILT), .WIN_CYC(WIN), .PROG_CYC(PROG)
    ) uut (
        .clk (clk), .rst (rst), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .oe_hv (oe_hv), .addr (addr), .data_in (din), .data_out (dout),
        .data_oe (data_oe), .rb_pulldown (rb_pulldown)
    );

    // Busy span monitor
    always @(negedge clk) begin
        if (rst) run = 0;
        else if (rb_pulldown) run = run + 1;
        else if (run != 0) begin
            last_run = run;
            run = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input int w, input logic oe_v);
        @(negedge clk); addr = a; din = d; oe_n = oe_v; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (w) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic o);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (5) @(negedge clk);
        d = dout; o = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && rb_pulldown; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_prog(input string req);
        int n;
        n = 0;
        while (!rb_pulldown && n < 200) begin
            @(negedge clk); n++;
        end
        check(req, rb_pulldown, 1);
        wait_idle();
    endtask

    task automatic expect_byte(input string req, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d;
        logic o;
        rd(a, d, o);
        check(req, d, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic o;

        // ---- R1: reset and power-up erase ----
        repeat (4) @(negedge clk);
        check("R1 busy during reset", rb_pulldown, 1);
        check("R1 data_oe during reset", data_oe, 0);
        @(negedge clk); #1 rst = 1'b0;
        wait_idle();
        check("R1 erase span low bound", (last_run >= DEPTH - 1), 1);
        check("R1 erase span high bound", (last_run <= DEPTH), 1);
        expect_byte("R1 erased 0x00", 8'h00, 8'hFF);
        expect_byte("R1 erased top", 8'hFF, 8'hFF);

        // ---- R2: read drives bus, standby releases it ----
        rd(8'h10, d, o);
        check("R2 read drives bus", o, 1);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 standby bus released", data_oe, 0);
        oe_n = 1'b1;

        // ---- vector table: R6 / R8 page loads ----
        for (int k = 0; k < 7; k++) begin
            wr(VEC[k].a, VEC[k].d, 5, 1'b1);
            if (VEC[k].flush) wait_prog("R7 table program starts");
        end
        for (int k = 0; k < 7; k++)
            expect_byte("R6 table readback", VEC[k].a, VEC[k].d);

        // ---- R6: full 64-byte page ----
        for (int k = 0; k < 64; k++) wr(8'hC0 + 8'(k), 8'(k) ^ 8'h96, 4, 1'b1);
        wait_prog("R6 full page program");
        check("R8 full page busy span", last_run, PROG);
        for (int k = 0; k < 64; k++) expect_byte("R6 full page byte", 8'hC0 + 8'(k), 8'(k) ^ 8'h96);

        // ---- R6: upper bits from first byte, same slot rewrite ----
        wr(8'h45, 8'h11, 5, 1'b1);
        wr(8'h83, 8'h22, 5, 1'b1);
        wait_prog("R6 page base load");
        expect_byte("R6 first byte", 8'h45, 8'h11);
        expect_byte("R6 upper bits from first", 8'h43, 8'h22);
        expect_byte("R6 foreign page untouched", 8'h83, 8'hFF);
        wr(8'h50, 8'h10, 5, 1'b1);
        wr(8'h50, 8'h20, 5, 1'b1);
        wait_prog("R6 rewrite load");
        expect_byte("R6 slot rewrite", 8'h50, 8'h20);
        expect_byte("R8 unloaded slot kept", 8'h51, 8'hFF);

        // ---- R3: output enable low inhibits ----
        wr(8'h60, 8'h00, 5, 1'b0);
        repeat (40) @(negedge clk);
        check("R3 inhibit no busy", rb_pulldown, 0);
        expect_byte("R3 inhibit no store", 8'h60, 8'hFF);

        // ---- R4: width filter ----
        wr(8'h61, 8'h00, 1, 1'b1);
        repeat (40) @(negedge clk);
        check("R4 width 1 no busy", rb_pulldown, 0);
        wr(8'h62, 8'h00, 2, 1'b1);
        repeat (40) @(negedge clk);
        check("R4 width 2 no busy", rb_pulldown, 0);
        expect_byte("R4 width 1 dropped", 8'h61, 8'hFF);
        expect_byte("R4 width 2 dropped", 8'h62, 8'hFF);
        wr(8'h63, 8'h33, 3, 1'b1);
        wait_prog("R4 width 3 accepted");
        expect_byte("R4 width 3 stored", 8'h63, 8'h33);

        // ---- R5: address at start, data at end ----
        @(negedge clk); addr = 8'h70; din = 8'h12; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 8'h71; din = 8'h34;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        wait_prog("R5 load");
        expect_byte("R5 first address used", 8'h70, 8'h34);
        expect_byte("R5 later address unused", 8'h71, 8'hFF);

        // ---- R7 window restart, R8 span, R10 polling, R9 ignore ----
        wr(8'h20, 8'h9C, 5, 1'b1);
        repeat (14) @(negedge clk);
        wr(8'h21, 8'h4D, 5, 1'b1);
        repeat (15) @(negedge clk);
        check("R7 window restarted", rb_pulldown, 0);
        for (int n = 0; n < 40 && !rb_pulldown; n++) @(negedge clk);
        check("R7 program after window", rb_pulldown, 1);
        rd(8'h20, d, o);
        check("R10 poll bus driven", o, 1);
        check("R10 poll value", d, 8'h80);
        wr(8'h22, 8'h5A, 5, 1'b1);
        wait_idle();
        check("R8 program span", last_run, PROG);
        expect_byte("R8 byte A", 8'h20, 8'h9C);
        expect_byte("R8 byte B", 8'h21, 8'h4D);
        repeat (40) @(negedge clk);
        check("R9 no second program", rb_pulldown, 0);
        expect_byte("R9 busy write ignored", 8'h22, 8'hFF);

        // ---- R11: chip clear ----
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1; oe_hv = 1'b0; ce_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 clear busy", rb_pulldown, 1);
        rd(8'h00, d, o);
        check("R10 clear poll value", d, 8'h00);
        wait_idle();
        check("R11 clear span", last_run, DEPTH);
        expect_byte("R11 cleared 0x00", 8'h00, 8'hFF);
        expect_byte("R11 cleared 0x45", 8'h45, 8'hFF);
        expect_byte("R11 cleared 0xC7", 8'hC7, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule